// File: doc/BRIEF.md
# Dual-Width Flag Adder and Extender

This block is the combinational arithmetic slice of a 24-bit datapath whose status word keeps two parallel groups of condition flags. One group describes the result as if it were 16 bits wide and the other as the full 24 bits. A single 24-bit addition produces the destination value and both flag groups at the same moment. The surrounding pipeline writes the result back to a register and merges the flags into the status word when the matching write-enables are high.

The second operand of an add can come from a register. It can also come from an immediate: an 8-bit value sign-extended, a 16-bit value sign-extended, or a 24-bit value built from a 16-bit word and an extra byte. The same unit carries out four in-place width conversions on the destination value. It also produces the high-half register for multiply and divide, filled from the sign of the destination's low 16 bits. These conversion operations never touch the flags.

The unit has no clock. Operation select, operands and immediates go in, and result, flags, high-half value and three write-enables come out in the same cycle. Operation codes 0 to 5 are defined. Codes 6 and 7 are idle.

Top module: `dualflag_alu`

## Requirements
- R1: For operation 0 (add), `res_out` equals (`dst_val` + addend) modulo 2^24 and `res_we` is 1.
- R2: The addend is chosen by `add_src`: 0 takes `src_val`; 1 takes `imm_word[7:0]` sign-extended; 2 takes `imm_word` sign-extended; 3 takes `{imm_word, imm_ext}`, with `imm_word` as the upper 16 bits.
- R3: On add, flag bit 0 (narrow zero) is set when `res_out[15:0]` is zero, and flag bit 4 (wide zero) is set when all 24 bits are zero.
- R4: On add, flag bit 1 (narrow negative) equals `res_out[15]`, and flag bit 5 (wide negative) equals `res_out[23]`.
- R5: On add, flag bit 2 (narrow carry) is set when `res_out[15:0]` is below the low 16 bits of either input. Flag bit 6 (wide carry) applies the same unsigned test to all 24 bits.
- R6: On add, flag bit 3 (narrow overflow) is set when both inputs agree in bit 15 and the result differs from them in that bit. Flag bit 7 (wide overflow) applies the same rule at bit 23.
- R7: `flags_we` is 1 only for add, and all eight flag bits are then driven with fresh values. For every other code, `flags_we` is 0 and `flags_out` is 0.
- R8: Operation 1 sets `mdr_we` to 1 and drives `mdr_out` to 0x00FFFF if `dst_val[15]` is 1, else 0. `res_we` is 0.
- R9: Operation 2 drives `res_out` to `dst_val[15:0]` sign-extended. Operation 3 drives it to `dst_val[15:0]` zero-extended. Both set `res_we`.
- R10: Operation 4 drives `res_out` to `dst_val[7:0]` sign-extended. Operation 5 drives it to `dst_val[7:0]` zero-extended. Both set `res_we`.
- R11: Codes 6 and 7 assert no write-enable. `add_src` and the immediates have no effect on operations 1 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code, 0 to 5 defined |
| add_src | input | 2 | Addend source for add |
| src_val | input | 24 | Source register value |
| dst_val | input | 24 | Destination register value (also the conversion input) |
| imm_word | input | 16 | Immediate word |
| imm_ext | input | 8 | Extension byte for the 24-bit immediate |
| res_out | output | 24 | Value for the destination register |
| res_we | output | 1 | Destination write-enable |
| flags_out | output | 8 | Flags: bits 3..0 = V,C,N,Z narrow; bits 7..4 = V,C,N,Z wide |
| flags_we | output | 1 | Status flag write-enable |
| mdr_out | output | 24 | Value for the multiply/divide high register |
| mdr_we | output | 1 | High register write-enable |

## Verification
The hardest cases to reach are the ones where the two flag groups disagree. One case is a carry or zero out of bit 15 that does not reach bit 23. The other is an overflow at bit 23 while the narrow group reports none. These only appear for operand pairs chosen around 0x00FFFF, 0x007FFF and 0x7FFFFF, so the stimulus is hand-picked at those edges rather than spread at random. It also drives each immediate form with its sign bit set. The conversions are repeated with `add_src` and the immediates changed, to show those inputs leave the results unchanged.

// File: rtl/dualflag_pkg.sv
package dualflag_pkg;

    parameter int unsigned WORD_W   = 24;
    parameter int unsigned HALF_W   = 16;
    parameter int unsigned BYTE_W   = 8;

    typedef enum logic [2:0] {
        OP_ADD      = 3'd0,
        OP_HI_SIGN  = 3'd1,
        OP_SEXT_H   = 3'd2,
        OP_ZEXT_H   = 3'd3,
        OP_SEXT_B   = 3'd4,
        OP_ZEXT_B   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ADD_REG   = 2'd0,
        ADD_IMM8  = 2'd1,
        ADD_IMM16 = 2'd2,
        ADD_IMM24 = 2'd3
    } add_src_e;

    // bit 0 is the narrow zero flag, bit 7 the wide overflow flag
    typedef struct packed {
        logic wv;
        logic wc;
        logic wn;
        logic wz;
        logic hv;
        logic hc;
        logic hn;
        logic hz;
    } flag_set_t;

endpackage

// File: rtl/dualflag_addend_sel.sv
module dualflag_addend_sel
    import dualflag_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned LOW_W  = HALF_W,
    parameter int unsigned EXT_W  = BYTE_W
) (
    input  add_src_e            sel,
    input  logic [DATA_W-1:0]   src_val,
    input  logic [LOW_W-1:0]    imm_word,
    input  logic [EXT_W-1:0]    imm_ext,
    output logic [DATA_W-1:0]   addend
);
    localparam int unsigned SX8_W  = DATA_W - EXT_W;
    localparam int unsigned SX16_W = DATA_W - LOW_W;

    logic [DATA_W-1:0] imm8_sx;
    logic [DATA_W-1:0] imm16_sx;
    logic [DATA_W-1:0] imm_full;

    always_comb begin
        imm8_sx  = {{SX8_W{imm_word[EXT_W-1]}}, imm_word[EXT_W-1:0]};
        imm16_sx = {{SX16_W{imm_word[LOW_W-1]}}, imm_word};
        imm_full = {imm_word, imm_ext};
    end

    always_comb begin
        unique case (sel)
            ADD_REG:   addend = src_val;
            ADD_IMM8:  addend = imm8_sx;
            ADD_IMM16: addend = imm16_sx;
            ADD_IMM24: addend = imm_full;
            default:   addend = '0;
        endcase
    end
endmodule

// File: rtl/dualflag_adder.sv
module dualflag_adder
    import dualflag_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned LOW_W  = HALF_W
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] sum,
    output flag_set_t         flags
);
    localparam int unsigned TOP  = DATA_W - 1;
    localparam int unsigned MID  = LOW_W - 1;

    logic [DATA_W:0] wide_sum;
    logic [LOW_W:0]  narrow_sum;

    // carries come from widened adders rather than result comparisons
    always_comb begin
        wide_sum   = {1'b0, lhs} + {1'b0, rhs};
        narrow_sum = {1'b0, lhs[MID:0]} + {1'b0, rhs[MID:0]};
        sum        = wide_sum[TOP:0];
    end

    always_comb begin
        flags.hz = (sum[MID:0] == '0);
        flags.hn = sum[MID];
        flags.hc = narrow_sum[LOW_W];
        flags.hv = (lhs[MID] == rhs[MID]) && (sum[MID] != lhs[MID]);
        flags.wz = (sum == '0);
        flags.wn = sum[TOP];
        flags.wc = wide_sum[DATA_W];
        flags.wv = (lhs[TOP] == rhs[TOP]) && (sum[TOP] != lhs[TOP]);
    end
endmodule

// File: rtl/dualflag_extend.sv
module dualflag_extend
    import dualflag_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned LOW_W  = HALF_W,
    parameter int unsigned EXT_W  = BYTE_W
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] conv,
    output logic [DATA_W-1:0] hi_fill
);
    localparam int unsigned PAD_H = DATA_W - LOW_W;
    localparam int unsigned PAD_B = DATA_W - EXT_W;

    logic h_sign;
    logic b_sign;

    always_comb begin
        h_sign  = value[LOW_W-1];
        b_sign  = value[EXT_W-1];
        hi_fill = {{PAD_H{1'b0}}, {LOW_W{h_sign}}};
    end

    always_comb begin
        unique case (op)
            OP_SEXT_H: conv = {{PAD_H{h_sign}}, value[LOW_W-1:0]};
            OP_ZEXT_H: conv = {{PAD_H{1'b0}},   value[LOW_W-1:0]};
            OP_SEXT_B: conv = {{PAD_B{b_sign}}, value[EXT_W-1:0]};
            OP_ZEXT_B: conv = {{PAD_B{1'b0}},   value[EXT_W-1:0]};
            default:   conv = '0;
        endcase
    end
endmodule

// File: rtl/dualflag_alu.sv
module dualflag_alu
    import dualflag_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned LOW_W  = HALF_W,
    parameter int unsigned EXT_W  = BYTE_W
) (
    input  logic [2:0]        op_sel,
    input  logic [1:0]        add_src,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [LOW_W-1:0]  imm_word,
    input  logic [EXT_W-1:0]  imm_ext,
    output logic [DATA_W-1:0] res_out,
    output logic              res_we,
    output logic [7:0]        flags_out,
    output logic              flags_we,
    output logic [DATA_W-1:0] mdr_out,
    output logic              mdr_we
);
    op_e               op;
    logic [DATA_W-1:0] addend;
    logic [DATA_W-1:0] sum;
    flag_set_t         add_flags;
    logic [DATA_W-1:0] conv;
    logic [DATA_W-1:0] hi_fill;

    always_comb op = op_e'(op_sel);

    dualflag_addend_sel #(.DATA_W(DATA_W), .LOW_W(LOW_W), .EXT_W(EXT_W)) u_sel (
        .sel      (add_src_e'(add_src)),
        .src_val  (src_val),
        .imm_word (imm_word),
        .imm_ext  (imm_ext),
        .addend   (addend)
    );

    dualflag_adder #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_add (
        .lhs   (dst_val),
        .rhs   (addend),
        .sum   (sum),
        .flags (add_flags)
    );

    dualflag_extend #(.DATA_W(DATA_W), .LOW_W(LOW_W), .EXT_W(EXT_W)) u_ext (
        .op      (op),
        .value   (dst_val),
        .conv    (conv),
        .hi_fill (hi_fill)
    );

    always_comb begin
        res_out   = '0;
        res_we    = 1'b0;
        flags_out = '0;
        flags_we  = 1'b0;
        mdr_out   = '0;
        mdr_we    = 1'b0;
        unique case (op)
            OP_ADD: begin
                res_out   = sum;
                res_we    = 1'b1;
                flags_out = add_flags;
                flags_we  = 1'b1;
            end
            OP_HI_SIGN: begin
                mdr_out = hi_fill;
                mdr_we  = 1'b1;
            end
            OP_SEXT_H, OP_ZEXT_H, OP_SEXT_B, OP_ZEXT_B: begin
                res_out = conv;
                res_we  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dualflag_alu_chk.sv
module dualflag_alu_chk #(
    parameter int unsigned DATA_W = 24
) (
    input logic [2:0]        op_sel,
    input logic [1:0]        add_src,
    input logic [DATA_W-1:0] src_val,
    input logic [DATA_W-1:0] dst_val,
    input logic [DATA_W-1:0] res_out,
    input logic              res_we,
    input logic [7:0]        flags_out,
    input logic              flags_we,
    input logic [DATA_W-1:0] mdr_out,
    input logic              mdr_we
);
    logic [DATA_W-1:0] reg_sum;
    always_comb reg_sum = dst_val + src_val;

    always_comb begin
        if (op_sel == 3'd0 && add_src == 2'd0) begin
            assert_reg_sum_R1: assert (res_out == reg_sum && res_we)
                else $error("R1 register add result mismatch");
        end
        if (flags_we && flags_out[4]) begin
            assert_wide_zero_narrow_R3: assert (flags_out[0])
                else $error("R3 wide zero without narrow zero");
        end
        if (flags_we) begin
            assert_sign_bits_R4: assert (flags_out[5] == res_out[DATA_W-1] && flags_out[1] == res_out[15])
                else $error("R4 sign flag mismatch");
        end
        assert_flags_add_only_R7: assert (!flags_we || op_sel == 3'd0)
            else $error("R7 flags written outside add");
        if (mdr_we) begin
            assert_hi_fill_R8: assert (mdr_out == (dst_val[15] ? 24'h00FFFF : 24'h0) && !res_we)
                else $error("R8 high register value mismatch");
        end
        if (op_sel == 3'd5) begin
            assert_zext_byte_R10: assert (res_out[DATA_W-1:8] == '0)
                else $error("R10 zero-extended byte has upper bits");
        end
        if (op_sel > 3'd5) begin
            assert_idle_codes_R11: assert (!res_we && !flags_we && !mdr_we)
                else $error("R11 idle code wrote state");
        end
    end
endmodule

bind dualflag_alu dualflag_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .op_sel    (op_sel),
    .add_src   (add_src),
    .src_val   (src_val),
    .dst_val   (dst_val),
    .res_out   (res_out),
    .res_we    (res_we),
    .flags_out (flags_out),
    .flags_we  (flags_we),
    .mdr_out   (mdr_out),
    .mdr_we    (mdr_we)
);

// File: tb/tb_dualflag_alu.sv
module tb_dualflag_alu;

    typedef struct {
        logic [23:0] res;
        logic        res_we;
        logic [7:0]  flg;
        logic        flg_we;
        logic [23:0] mdr;
        logic        mdr_we;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = 3'd6;
    logic [1:0]  add_src = 2'd0;
    logic [23:0] src_val = '0;
    logic [23:0] dst_val = '0;
    logic [15:0] imm_word = '0;
    logic [7:0]  imm_ext = '0;
    logic [23:0] res_out;
    logic        res_we;
    logic [7:0]  flags_out;
    logic        flags_we;
    logic [23:0] mdr_out;
    logic        mdr_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    dualflag_alu dut (
        .op_sel(op_sel), .add_src(add_src), .src_val(src_val), .dst_val(dst_val),
        .imm_word(imm_word), .imm_ext(imm_ext), .res_out(res_out), .res_we(res_we),
        .flags_out(flags_out), .flags_we(flags_we), .mdr_out(mdr_out), .mdr_we(mdr_we)
    );

    function automatic exp_t model(input logic [2:0] op, input logic [1:0] s,
                                   input logic [23:0] a, input logic [23:0] d,
                                   input logic [15:0] w, input logic [7:0] e, input string tag);
        exp_t x;
        logic [23:0] ad, v;
        x = '{res: 24'h0, res_we: 1'b0, flg: 8'h0, flg_we: 1'b0, mdr: 24'h0, mdr_we: 1'b0, tag: tag};
        case (s)
            2'd0: ad = a;
            2'd1: ad = {{16{w[7]}}, w[7:0]};
            2'd2: ad = {{8{w[15]}}, w};
            default: ad = {w, e};
        endcase
        case (op)
            3'd0: begin
                v = d + ad;
                x.res = v; x.res_we = 1'b1; x.flg_we = 1'b1;
                x.flg[0] = (v[15:0] == 16'h0);
                x.flg[1] = v[15];
                x.flg[2] = (v[15:0] < d[15:0]) || (v[15:0] < ad[15:0]);
                x.flg[3] = (d[15] == ad[15]) && (v[15] != d[15]);
                x.flg[4] = (v == 24'h0);
                x.flg[5] = v[23];
                x.flg[6] = (v < d) || (v < ad);
                x.flg[7] = (d[23] == ad[23]) && (v[23] != d[23]);
            end
            3'd1: begin x.mdr = d[15] ? 24'h00FFFF : 24'h0; x.mdr_we = 1'b1; end
            3'd2: begin x.res = {{8{d[15]}}, d[15:0]}; x.res_we = 1'b1; end
            3'd3: begin x.res = {8'h0, d[15:0]}; x.res_we = 1'b1; end
            3'd4: begin x.res = {{16{d[7]}}, d[7:0]}; x.res_we = 1'b1; end
            3'd5: begin x.res = {16'h0, d[7:0]}; x.res_we = 1'b1; end
            default: ;
        endcase
        return x;
    endfunction

    task automatic drive(input logic [2:0] op, input logic [1:0] s, input logic [23:0] a,
                         input logic [23:0] d, input logic [15:0] w, input logic [7:0] e,
                         input string tag);
        @(posedge clk);
        op_sel = op; add_src = s; src_val = a; dst_val = d; imm_word = w; imm_ext = e;
        sb.push_back(model(op, s, a, d, w, e, tag));
    endtask

    // monitor: one expected item per cycle, sampled on the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            n_checks++;
            if (res_out !== x.res || res_we !== x.res_we || flags_out !== x.flg ||
                flags_we !== x.flg_we || mdr_out !== x.mdr || mdr_we !== x.mdr_we) begin
                n_fail++;
                $display("FAIL %s: got res=%h/%b flg=%h/%b mdr=%h/%b exp res=%h/%b flg=%h/%b mdr=%h/%b",
                         x.tag, res_out, res_we, flags_out, flags_we, mdr_out, mdr_we,
                         x.res, x.res_we, x.flg, x.flg_we, x.mdr, x.mdr_we);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(3'd6, 2'd0, 24'h0, 24'h0, 16'h0, 8'h0, "R11 idle state after reset");
        drive(3'd0, 2'd0, 24'h000003, 24'h000004, 16'h0, 8'h0, "R1 plain add");
        drive(3'd0, 2'd0, 24'h000001, 24'h00FFFF, 16'h0, 8'h0, "R3 R5 narrow zero and carry only");
        drive(3'd0, 2'd0, 24'h000001, 24'hFFFFFF, 16'h0, 8'h0, "R3 R5 both zero and carry");
        drive(3'd0, 2'd0, 24'h000001, 24'h007FFF, 16'h0, 8'h0, "R4 R6 narrow overflow only");
        drive(3'd0, 2'd0, 24'h000001, 24'h7FFFFF, 16'h0, 8'h0, "R4 R6 wide overflow");
        drive(3'd0, 2'd0, 24'h800000, 24'h800000, 16'h0, 8'h0, "R6 wide negative overflow");
        drive(3'd0, 2'd0, 24'h123456, 24'h654321, 16'h0, 8'h0, "R1 mixed values");
        drive(3'd0, 2'd1, 24'hABCDEF, 24'h000100, 16'h0080, 8'h0, "R2 imm8 negative");
        drive(3'd0, 2'd1, 24'h0, 24'h000010, 16'hFF7F, 8'h0, "R2 imm8 positive ignores upper byte");
        drive(3'd0, 2'd2, 24'h0, 24'h010000, 16'h8000, 8'h0, "R2 imm16 negative");
        drive(3'd0, 2'd2, 24'h0, 24'h00F000, 16'h1000, 8'h0, "R2 imm16 carry");
        drive(3'd0, 2'd3, 24'h0, 24'h000001, 16'h1234, 8'h56, "R2 imm24 assembly");
        drive(3'd0, 2'd3, 24'h0, 24'h000001, 16'hFFFF, 8'hFF, "R2 imm24 wrap to zero");
        drive(3'd1, 2'd0, 24'h0, 24'h008000, 16'h0, 8'h0, "R8 high fill negative");
        drive(3'd1, 2'd3, 24'hFFFFFF, 24'hFF7FFF, 16'hFFFF, 8'hFF, "R8 high fill positive");
        drive(3'd2, 2'd0, 24'h0, 24'h128001, 16'h0, 8'h0, "R9 sign-extend half negative");
        drive(3'd2, 2'd0, 24'h0, 24'hAB7001, 16'h0, 8'h0, "R9 sign-extend half positive");
        drive(3'd3, 2'd0, 24'h0, 24'hAB9001, 16'h0, 8'h0, "R9 zero-extend half");
        drive(3'd4, 2'd0, 24'h0, 24'h123480, 16'h0, 8'h0, "R10 sign-extend byte negative");
        drive(3'd4, 2'd0, 24'h0, 24'hFFFF7F, 16'h0, 8'h0, "R10 sign-extend byte positive");
        drive(3'd5, 2'd0, 24'h0, 24'hFFFFA5, 16'h0, 8'h0, "R10 zero-extend byte");
        drive(3'd2, 2'd3, 24'h555555, 24'h128001, 16'hFFFF, 8'hFF, "R11 add_src ignored on conversion");
        drive(3'd5, 2'd1, 24'h555555, 24'hFFFFA5, 16'h1234, 8'h56, "R11 immediates ignored on conversion");
        drive(3'd6, 2'd0, 24'h111111, 24'hFFFFFF, 16'h1, 8'h1, "R11 code 6 idle");
        drive(3'd7, 2'd3, 24'hFFFFFF, 24'h008000, 16'hFFFF, 8'hFF, "R7 R11 code 7 idle");
        drive(3'd3, 2'd0, 24'h0, 24'h00FFFF, 16'h0, 8'h0, "R7 no flags on conversion");
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule